// File: doc/BRIEF.md
# SPI Serial Controller (Master or Slave)

This block moves 8-bit bytes over a four-wire SPI bus. One shift register sends a byte and takes one in at the same time. A static mode input selects master or slave. As master the block makes the serial clock from the system clock through a power-of-two prescaler and pulls its select output low for the whole byte. As slave it follows a clock, data and select that come from outside. It passes them through two-flop synchronizers and drives MISO only while it is selected. The bus runs in mode 0: SCK idles low, both ends sample on the rising edge and change data on the falling edge.

The host writes a byte to start a master transfer, or to preload the slave reply. The received byte is read from `rdata_o`. A completion flag drives an interrupt output when the interrupt is enabled. A collision flag records a host write that arrives while a byte is being shifted. Both flags clear on a status read that is followed by a data register access. When the enable input is low the block ignores the host and the bus.

Top module: `spi_ctrl`

## Requirements
- R1: In master mode a byte written while idle is sent on MOSI while the byte on MISO is taken in, both on the same SCK. MISO is sampled on each rising SCK edge, and MOSI changes after each falling edge.
- R2: In slave mode the block drives no clock. While enabled and with ss_ni low it drives MISO (miso_oe_o = 1) with the preloaded byte and takes in MOSI on the rising edges of sck_i.
- R3: As master, ss_no goes low before the first SCK edge, stays low for the whole byte and is high while idle.
- R4: lsb_first_i = 1 shifts bit 0 first and lsb_first_i = 0 shifts bit 7 first, for both send and receive.
- R5: With dbl_speed_i = 0 the SCK period is 4, 16, 64 and 128 system clocks for rate_i = 0, 1, 2 and 3.
- R6: dbl_speed_i = 1 halves the SCK period in master mode, so rate_i = 0 gives 2 clocks and rate_i = 1 gives 8.
- R7: done_flag_o sets when the eighth bit completes, and irq_o is high only while done_flag_o and irq_en_i are both high.
- R8: wcol_flag_o sets when wr_data_i is pulsed while a byte is being shifted.
- R9: While en_i is low, host writes and bus activity have no effect: ss_no stays high, sck_o stays low, miso_oe_o is low and no flag sets.
- R10: A colliding write is dropped, and the byte in flight finishes unchanged.
- R11: Both flags clear only when an rd_status_i pulse is followed by an rd_data_i or wr_data_i pulse. A data access with no status read before it leaves them set.
- R12: In slave mode, if ss_ni rises partway through a byte, the bit count restarts, MISO is released and no completion flag sets.
- R13: rdata_o takes the received byte when a byte completes and holds it until the next byte completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| master_i | input | 1 | 1 = master, 0 = slave |
| lsb_first_i | input | 1 | Bit order select |
| dbl_speed_i | input | 1 | Halves the master SCK divider |
| rate_i | input | 2 | Prescaler select |
| irq_en_i | input | 1 | Interrupt enable |
| wr_data_i | input | 1 | Data register write strobe |
| wdata_i | input | 8 | Data to write |
| rd_data_i | input | 1 | Data register read strobe |
| rd_status_i | input | 1 | Status read strobe |
| rdata_o | output | 8 | Last received byte |
| done_flag_o | output | 1 | Transfer complete flag |
| wcol_flag_o | output | 1 | Write collision flag |
| irq_o | output | 1 | Interrupt request |
| sck_o | output | 1 | Master serial clock |
| mosi_o | output | 1 | Master data out |
| miso_i | input | 1 | Master data in |
| ss_no | output | 1 | Master slave select, active low |
| sck_i | input | 1 | Slave serial clock |
| mosi_i | input | 1 | Slave data in |
| ss_ni | input | 1 | Slave select, active low |
| miso_o | output | 1 | Slave data out |
| miso_oe_o | output | 1 | Slave MISO drive enable |

## Verification
The assertions check on every cycle that SCK is high only while select is low and that a disabled block holds its master lines idle. They also check that each flag edge follows the strobe that may cause it, that a completed byte always raises the completion flag, and that the read data moves only on completion. The bench scenarios alone can show the bit values on the wires in both orders, the exact SCK period for each prescaler and speed setting, and that a collided write leaves the byte in flight unchanged. They also cover a slave byte cut short by select with a full byte after it, and the two-step flag clear.

// File: rtl/spi_pkg.sv
package spi_pkg;
  localparam int DATA_W = 8;
  localparam int HALF_W = 7;

  // half SCK period in system clocks: full divider 4/16/64/128, halved when dbl
  function automatic logic [HALF_W-1:0] half_cycles(input logic [1:0] rate, input logic dbl);
    logic [2:0] e;
    logic [HALF_W-1:0] one;
    one = 1;
    case (rate)
      2'd0:    e = 3'd1;
      2'd1:    e = 3'd3;
      2'd2:    e = 3'd5;
      default: e = 3'd6;
    endcase
    if (dbl) e = e - 3'd1;
    return one << e;
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= {2{RST_VAL[i]}};
      else         ff <= {ff[0], d_i[i]};
    end
    assign q_o[i] = ff[1];
  end
endmodule

// File: rtl/spi_clkgen.sv
module spi_clkgen #(
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] half_i,
  output logic         tick_o
);
  logic [W-1:0] cnt;

  assign tick_o = run_i && (cnt == half_i - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt <= '0;
    else if (!run_i || tick_o)  cnt <= '0;
    else                        cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         load_i,
  input  logic [W-1:0] load_data_i,
  input  logic         lsb_first_i,
  input  logic         sample_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic         sdo_o,
  output logic [W-1:0] data_o,
  output logic         last_o,
  output logic         done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  sh;
  logic [CW-1:0] cnt;
  logic          samp;
  logic          done_q;

  assign sdo_o  = lsb_first_i ? sh[0] : sh[W-1];
  assign last_o = shift_i && !clr_i && (cnt == LAST);
  assign data_o = sh;
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh     <= '0;
      cnt    <= '0;
      samp   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (load_i)                 sh <= load_data_i;
      else if (shift_i && !clr_i) sh <= lsb_first_i ? {samp, sh[W-1:1]} : {sh[W-2:0], samp};
      if (clr_i || load_i)        cnt <= '0;
      else if (shift_i)           cnt <= last_o ? '0 : cnt + 1'b1;
      if (sample_i && !clr_i)     samp <= sdi_i;
    end
  end
endmodule

// File: rtl/spi_ctrl.sv
module spi_ctrl
  import spi_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              master_i,
  input  logic              lsb_first_i,
  input  logic              dbl_speed_i,
  input  logic [1:0]        rate_i,
  input  logic              irq_en_i,
  input  logic              wr_data_i,
  input  logic [DATA_W_P-1:0] wdata_i,
  input  logic              rd_data_i,
  input  logic              rd_status_i,
  output logic [DATA_W_P-1:0] rdata_o,
  output logic              done_flag_o,
  output logic              wcol_flag_o,
  output logic              irq_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              ss_no,
  input  logic              sck_i,
  input  logic              mosi_i,
  input  logic              ss_ni,
  output logic              miso_o,
  output logic              miso_oe_o
);
  logic [HALF_W-1:0] half;
  logic [2:0] sync_q;
  logic s_sck, s_mosi, s_ss, sck_d;
  logic slave_sel, s_rise, s_fall, s_busy;
  logic m_busy, sck_q, tick, m_rise, m_fall;
  logic busy, accept, collide, sh_clr;
  logic sdo, last, xfer_done;
  logic [DATA_W_P-1:0] sh_data, rx_q;
  logic done_q, wcol_q, arm_q, clear;

  assign half = half_cycles(rate_i, dbl_speed_i);

  spi_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i, .rst_ni, .d_i({ss_ni, mosi_i, sck_i}), .q_o(sync_q)
  );
  assign s_sck  = sync_q[0];
  assign s_mosi = sync_q[1];
  assign s_ss   = sync_q[2];

  assign slave_sel = en_i && !master_i && !s_ss;
  assign s_rise    = slave_sel && s_sck && !sck_d;
  assign s_fall    = slave_sel && !s_sck && sck_d;

  spi_clkgen #(.W(HALF_W)) u_clkgen (
    .clk_i, .rst_ni, .run_i(m_busy), .half_i(half), .tick_o(tick)
  );
  assign m_rise = m_busy && tick && !sck_q;
  assign m_fall = m_busy && tick && sck_q;

  assign busy    = master_i ? m_busy : s_busy;
  assign accept  = en_i && wr_data_i && !busy;
  assign collide = en_i && wr_data_i && busy;
  assign sh_clr  = !en_i || (!master_i && s_ss);

  spi_shifter #(.W(DATA_W_P)) u_shift (
    .clk_i, .rst_ni,
    .clr_i(sh_clr),
    .load_i(accept),
    .load_data_i(wdata_i),
    .lsb_first_i,
    .sample_i(master_i ? m_rise : s_rise),
    .shift_i(master_i ? m_fall : s_fall),
    .sdi_i(master_i ? miso_i : s_mosi),
    .sdo_o(sdo),
    .data_o(sh_data),
    .last_o(last),
    .done_o(xfer_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy <= 1'b0;
      sck_q  <= 1'b0;
    end else if (!en_i) begin
      m_busy <= 1'b0;
      sck_q  <= 1'b0;
    end else if (accept && master_i) begin
      m_busy <= 1'b1;
      sck_q  <= 1'b0;
    end else if (m_rise) begin
      sck_q  <= 1'b1;
    end else if (m_fall) begin
      sck_q  <= 1'b0;
      if (last) m_busy <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d  <= 1'b0;
      s_busy <= 1'b0;
    end else begin
      sck_d <= s_sck;
      if (sh_clr)                     s_busy <= 1'b0;
      else if (!master_i && s_rise)   s_busy <= 1'b1;
      else if (!master_i && last)     s_busy <= 1'b0;
    end
  end

  // flags clear on status read then data access
  assign clear = arm_q && (rd_data_i || wr_data_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q   <= '0;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (xfer_done) rx_q <= sh_data;
      done_q <= (done_q && !clear) || xfer_done;
      wcol_q <= (wcol_q && !clear) || collide;
      if (rd_status_i && (done_q || wcol_q)) arm_q <= 1'b1;
      else if (clear)                        arm_q <= 1'b0;
    end
  end

  assign rdata_o     = rx_q;
  assign done_flag_o = done_q;
  assign wcol_flag_o = wcol_q;
  assign irq_o       = irq_en_i && done_q;
  assign sck_o       = sck_q;
  assign ss_no       = !m_busy;
  assign mosi_o      = (master_i && m_busy) ? sdo : 1'b0;
  assign miso_o      = sdo;
  assign miso_oe_o   = slave_sel;
endmodule

// File: rtl/spi_ctrl_chk.sv
module spi_ctrl_chk #(
  parameter int DATA_W_P = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                wr_data_i,
  input logic                rd_data_i,
  input logic                sck_o,
  input logic                ss_no,
  input logic                done_flag_o,
  input logic                wcol_flag_o,
  input logic [DATA_W_P-1:0] rdata_o,
  input logic                xfer_done
);
  // R3
  sck_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> !ss_no);

  // R9
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (ss_no && !sck_o));

  // R7
  done_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_done |=> done_flag_o);

  // R8
  wcol_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wcol_flag_o) |-> $past(wr_data_i));

  // R11
  done_clear_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_flag_o) |-> $past(rd_data_i || wr_data_i));

  // R13
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_done |=> $stable(rdata_o));
endmodule

bind spi_ctrl spi_ctrl_chk #(.DATA_W_P(DATA_W_P)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .wr_data_i(wr_data_i),
  .rd_data_i(rd_data_i), .sck_o(sck_o), .ss_no(ss_no),
  .done_flag_o(done_flag_o), .wcol_flag_o(wcol_flag_o),
  .rdata_o(rdata_o), .xfer_done(xfer_done)
);

// File: tb/spi_ctrl_test.sv
module spi_ctrl_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0, master_i = 1'b1, lsb_first_i = 1'b0, dbl_speed_i = 1'b0;
  logic [1:0] rate_i = 2'd0;
  logic irq_en_i = 1'b0, wr_data_i = 1'b0, rd_data_i = 1'b0, rd_status_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic done_flag_o, wcol_flag_o, irq_o, sck_o, mosi_o, ss_no, miso_o, miso_oe_o;
  logic miso_i = 1'b0, sck_i = 1'b0, mosi_i = 1'b0, ss_ni = 1'b1;

  int n_tests = 0, n_fail = 0, cyc = 0;
  logic [7:0] exp_q[$];
  logic [7:0] sl_tx = 8'h00, cap = 8'h00;
  int t_rise[8];
  logic [7:0] ss_at = 8'h00;
  logic done_prev = 1'b0;
  logic finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  spi_ctrl uut (
    .clk_i(clk), .rst_ni, .en_i, .master_i, .lsb_first_i, .dbl_speed_i, .rate_i,
    .irq_en_i, .wr_data_i, .wdata_i, .rd_data_i, .rd_status_i, .rdata_o,
    .done_flag_o, .wcol_flag_o, .irq_o, .sck_o, .mosi_o, .miso_i, .ss_no,
    .sck_i, .mosi_i, .ss_ni, .miso_o, .miso_oe_o
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench-side slave for master transfers
  initial forever begin
    @(negedge ss_no);
    for (int i = 0; i < 8; i++) begin
      int idx;
      idx = lsb_first_i ? i : 7 - i;
      miso_i = sl_tx[idx];
      @(posedge sck_o);
      t_rise[i] = cyc;
      ss_at[i]  = ss_no;
      cap[idx]  = mosi_o;
      @(negedge sck_o);
    end
  end

  // scoreboard monitor: R1/R13 received byte on each completion
  initial forever begin
    @(negedge clk);
    if (done_flag_o && !done_prev) begin
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R13 unexpected completion: actual=%0h expected=none", rdata_o);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rdata_o !== e) begin
          n_fail++;
          $display("FAIL R13 rx byte: actual=%0h expected=%0h", rdata_o, e);
        end
      end
    end
    done_prev = done_flag_o;
  end

  task automatic host_write(input logic [7:0] d);
    @(negedge clk); wr_data_i = 1'b1; wdata_i = d;
    @(negedge clk); wr_data_i = 1'b0;
  endtask

  task automatic clear_flags();
    @(negedge clk); rd_status_i = 1'b1;
    @(negedge clk); rd_status_i = 1'b0; rd_data_i = 1'b1;
    @(negedge clk); rd_data_i = 1'b0;
  endtask

  task automatic master_xfer(input logic [7:0] tx, input logic [7:0] stx, input string req);
    sl_tx = stx;
    exp_q.push_back(stx);
    host_write(tx);
    wait (done_flag_o == 1'b1);
    @(negedge clk);
    chk(req, "mosi byte", cap, tx);
    chk("R3", "ss low at every rise", ss_at, 8'h00);
    chk("R3", "ss high after byte", ss_no, 1'b1);
  endtask

  task automatic slave_xfer(input logic [7:0] mtx, input int nbits, output logic [7:0] got, output logic oe0);
    got = 8'h00; oe0 = 1'b0;
    @(negedge clk); ss_ni = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      mosi_i = mtx[7-i];
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      got[7-i] = miso_o;
      if (i == 0) oe0 = miso_oe_o;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_ni = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [7:0] got;
    logic oe0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R3", "reset ss_no", ss_no, 1'b1);
    chk("R1", "reset sck_o", sck_o, 1'b0);
    chk("R7", "reset flags", {done_flag_o, wcol_flag_o, irq_o}, 3'b000);
    chk("R9", "reset miso_oe", miso_oe_o, 1'b0);

    en_i = 1'b1; master_i = 1'b1; irq_en_i = 1'b1;
    // R1 msb first, rate 0
    master_xfer(8'hA5, 8'h3C, "R1");
    chk("R5", "period rate0", t_rise[1] - t_rise[0], 4);
    clear_flags();
    chk("R11", "done cleared", done_flag_o, 1'b0);

    // R4 lsb first, rate 1
    lsb_first_i = 1'b1; rate_i = 2'd1;
    master_xfer(8'h4D, 8'hB2, "R4");
    chk("R5", "period rate1", t_rise[1] - t_rise[0], 16);
    clear_flags();

    lsb_first_i = 1'b0; rate_i = 2'd3;
    master_xfer(8'h17, 8'hE8, "R1");
    chk("R5", "period rate3", t_rise[1] - t_rise[0], 128);
    clear_flags();

    rate_i = 2'd2;
    master_xfer(8'h60, 8'h0B, "R1");
    chk("R5", "period rate2", t_rise[1] - t_rise[0], 64);
    clear_flags();

    dbl_speed_i = 1'b1; rate_i = 2'd0;
    master_xfer(8'hC6, 8'h39, "R6");
    chk("R6", "period dbl rate0", t_rise[1] - t_rise[0], 2);
    clear_flags();
    rate_i = 2'd1;
    master_xfer(8'h2B, 8'hD4, "R6");
    chk("R6", "period dbl rate1", t_rise[1] - t_rise[0], 8);
    clear_flags();
    dbl_speed_i = 1'b0;

    // R8/R10 collision
    sl_tx = 8'h5E;
    exp_q.push_back(8'h5E);
    host_write(8'hA1);
    repeat (10) @(negedge clk);
    host_write(8'hFF);
    chk("R8", "wcol after busy write", wcol_flag_o, 1'b1);
    wait (done_flag_o == 1'b1);
    @(negedge clk);
    chk("R10", "byte in flight kept", cap, 8'hA1);
    chk("R13", "rdata after collision", rdata_o, 8'h5E);

    // R7 irq gating
    chk("R7", "irq with enable", irq_o, 1'b1);
    irq_en_i = 1'b0;
    @(negedge clk);
    chk("R7", "irq masked", irq_o, 1'b0);
    irq_en_i = 1'b1;

    // R11 data read alone does not clear
    @(negedge clk); rd_data_i = 1'b1;
    @(negedge clk); rd_data_i = 1'b0;
    @(negedge clk);
    chk("R11", "flags kept w/o status read", {done_flag_o, wcol_flag_o}, 2'b11);
    clear_flags();
    @(negedge clk);
    chk("R11", "flags cleared", {done_flag_o, wcol_flag_o}, 2'b00);
    chk("R13", "rdata held", rdata_o, 8'h5E);

    // R9 disabled
    en_i = 1'b0;
    host_write(8'h77);
    repeat (20) @(negedge clk);
    chk("R9", "ss idle disabled", {ss_no, sck_o}, 2'b10);
    master_i = 1'b0; ss_ni = 1'b0;
    repeat (4) @(negedge clk);
    chk("R9", "miso_oe disabled", miso_oe_o, 1'b0);
    for (int i = 0; i < 8; i++) begin
      repeat (6) @(negedge clk); sck_i = 1'b1;
      repeat (6) @(negedge clk); sck_i = 1'b0;
    end
    ss_ni = 1'b1;
    repeat (6) @(negedge clk);
    en_i = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9", "no flag while disabled", done_flag_o, 1'b0);

    // R2 slave transfer
    host_write(8'h96);
    exp_q.push_back(8'hA7);
    slave_xfer(8'hA7, 8, got, oe0);
    chk("R2", "miso byte", got, 8'h96);
    chk("R2", "miso driven when selected", oe0, 1'b1);
    chk("R7", "slave done", done_flag_o, 1'b1);
    clear_flags();

    // R12 abort then full byte
    host_write(8'h0F);
    slave_xfer(8'hFF, 3, got, oe0);
    chk("R12", "miso released", miso_oe_o, 1'b0);
    chk("R12", "no flag on abort", done_flag_o, 1'b0);
    host_write(8'hC3);
    exp_q.push_back(8'h5A);
    slave_xfer(8'h5A, 8, got, oe0);
    chk("R12", "miso after restart", got, 8'hC3);
    chk("R12", "done after restart", done_flag_o, 1'b1);
    chk("R13", "slave rdata", rdata_o, 8'h5A);
    clear_flags();
    repeat (4) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog all: actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule